// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a main-memory port that moves one 32-bit word per handshake. It keeps a small number of lines, each several words long, and looks each request up by a single index. A request whose line is present and tagged correctly completes in the same cycle it is presented. Any other request holds the processor off while the whole line is brought in from memory, one word per transfer, starting at word zero.

Stores that hit change only the cached copy and mark the line as modified. When a miss must replace a modified line, the old line is first copied into a one-line holding buffer. The memory port then serves the refill of the new line before it writes the held line back. That write-back runs in the background while the processor keeps hitting, and it always finishes before another refill may start. A store that misses first refills the line and then merges its word, so the line ends up marked modified.

With the default parameters there are 4 lines of 4 words and byte addresses are 8 bits wide.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is split, from low to high, into byte-in-word (bits 1:0, never used for lookup), word-in-line (bits 3:2), line index (bits 5:4) and tag (bits 7:6). Two addresses that differ only in bits 1:0 return the same word. Every memory-port address has bits 1:0 at zero.
- R2: After reset every line is invalid, so the first access to any address is a miss. During reset `cpu_ready` and `mem_req` are low.
- R3: An access whose indexed line is valid and holds an equal tag is a hit. `cpu_ready` is high in the first cycle the request is presented, and no memory read is issued for it.
- R4: A miss (invalid line, or valid line with another tag) keeps `cpu_ready` low while the line is fetched. The fetch is exactly WORDS reads of that line's addresses, in word order 0 to WORDS-1, and `cpu_ready` is never high while a refill read is requested.
- R5: A read returns the latest value written to that address by the processor, or the memory word if the processor never wrote it.
- R6: A store hit updates the cached word only. Main memory keeps its old value until the line is evicted.
- R7: Evicting a modified line writes all of its words back to their own addresses. No write-back transfer falls between the first and last read of a refill.
- R8: A store miss refills the line, then writes the store data into it. A later read of that address returns the store data.
- R9: A held line is fully written back before the next refill read, so an evicted address that is read straight back returns the modified data.
- R10: Evicting an unmodified line causes no memory write.
- R11: A memory transfer happens only on `mem_req` and `mem_ready` together. While `mem_req` is high and `mem_ready` low, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | ADDR_W | Word-aligned byte address of the transfer |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |

## Verification
The access stream mixes cold misses, repeated hits to a line just filled, and pairs of addresses with the same index but different tags. These tell a true tag compare apart from a check of the valid bit alone. Store hits are followed by reads of memory that must still hold the old value. This shows that only the cache was changed. Evictions of modified lines are followed by reads of memory and by immediate re-reads of the victim address, which separates correct drain ordering from a refill that overtakes the held line. Clean evictions, byte-offset aliases and a reset in the middle of the run check that no write occurs, that the word select is right and that contents are dropped. The memory stalls one cycle in four, so every handshake path is taken.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;

  // Byte lanes per data word are fixed by the port word size.
  localparam int BYTE_BITS = 8;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;

endpackage

// File: rtl/cache_addr_split.sv
`timescale 1ns/1ps
module cache_addr_split #(
  parameter int ADDR_W = 8,
  parameter int BOFF_W = 2,
  parameter int WO_W   = 2,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - BOFF_W - WO_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [WO_W-1:0]   woff,
  output logic [BOFF_W-1:0] boff
);

  localparam int WO_LO  = BOFF_W;
  localparam int IDX_LO = BOFF_W + WO_W;
  localparam int TAG_LO = BOFF_W + WO_W + IDX_W;

  // Fields are plain bit slices: division and modulo by powers of two.
  assign boff = addr[BOFF_W-1:0];
  assign woff = addr[WO_LO  +: WO_W];
  assign idx  = addr[IDX_LO +: IDX_W];
  assign tag  = addr[TAG_LO +: TAG_W];

endmodule

// File: rtl/cache_store.sv
`timescale 1ns/1ps
module cache_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2,
  localparam int IDX_W = $clog2(LINES),
  localparam int WO_W  = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [WO_W-1:0]         rd_woff,
  output logic                    rd_valid,
  output logic                    rd_dirty,
  output logic [TAG_W-1:0]        rd_tag,
  output logic [DATA_W-1:0]       rd_word,
  output logic [WORDS*DATA_W-1:0] rd_line,
  input  logic                    fill_we,
  input  logic [WO_W-1:0]         fill_woff,
  input  logic [DATA_W-1:0]       fill_data,
  input  logic                    fill_done,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic                    cpu_we,
  input  logic [DATA_W-1:0]       cpu_data
);

  logic [LINES-1:0]  valid_q, valid_d;
  logic [LINES-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][WORDS];

  // Line state next value: a finished refill validates and cleans the line,
  // a store hit marks it modified.
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_done) begin
      valid_d[rd_idx] = 1'b1;
      dirty_d[rd_idx] = 1'b0;
    end else if (cpu_we) begin
      dirty_d[rd_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // Tag array: written once per refill.
  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_q[rd_idx] <= fill_tag;
    end
  end

  // Data array: refill words and store hits never coincide.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      data_q[rd_idx][fill_woff] <= fill_data;
    end else if (cpu_we) begin
      data_q[rd_idx][rd_woff] <= cpu_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_word  = data_q[rd_idx][rd_woff];

  for (genvar w = 0; w < WORDS; w++) begin : g_line_out
    assign rd_line[w*DATA_W +: DATA_W] = data_q[rd_idx][w];
  end

endmodule

// File: rtl/cache_wbuf.sv
`timescale 1ns/1ps
module cache_wbuf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  localparam int WO_W   = $clog2(WORDS),
  localparam int BOFF_W = ADDR_W - TAG_W - IDX_W - WO_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [TAG_W-1:0]        load_tag,
  input  logic [IDX_W-1:0]        load_idx,
  input  logic [WORDS*DATA_W-1:0] load_line,
  input  logic                    hold,
  output logic                    busy,
  output logic                    req,
  output logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       wdata,
  input  logic                    mem_ready
);

  localparam logic [WO_W-1:0] LAST = WO_W'(WORDS - 1);

  logic              busy_q, busy_d;
  logic [WO_W-1:0]   cnt_q, cnt_d;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] word_q [WORDS];
  logic              xfer;

  // Drain only while the refill engine does not own the port.
  assign req   = busy_q && !hold;
  assign xfer  = req && mem_ready;
  assign busy  = busy_q;
  assign addr  = {tag_q, idx_q, cnt_q, {BOFF_W{1'b0}}};
  assign wdata = word_q[cnt_q];

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (xfer) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= load_tag;
      idx_q <= load_idx;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_hold
    always_ff @(posedge clk) begin
      if (load) begin
        word_q[w] <= load_line[w*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WO_W = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            hit,
  input  logic            victim_dirty,
  input  logic            buf_busy,
  input  logic            mem_ready,
  output logic            cpu_ready,
  output logic            fill_active,
  output logic [WO_W-1:0] fill_woff,
  output logic            fill_we,
  output logic            fill_done,
  output logic            buf_load
);

  localparam logic [WO_W-1:0] LAST = WO_W'(WORDS - 1);

  fill_state_e     state_q, state_d;
  logic [WO_W-1:0] cnt_q, cnt_d;
  logic            idle;
  logic            start;

  assign idle        = (state_q == FILL_IDLE);
  assign cpu_ready   = idle && cpu_valid && hit;
  // A miss waits in idle until the held victim has drained.
  assign start       = idle && cpu_valid && !hit && !buf_busy;
  assign buf_load    = start && victim_dirty;
  assign fill_active = (state_q == FILL_RUN);
  assign fill_woff   = cnt_q;
  assign fill_we     = fill_active && mem_ready;
  assign fill_done   = fill_we && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      FILL_IDLE: begin
        if (start) begin
          state_d = FILL_RUN;
          cnt_d   = '0;
        end
      end
      FILL_RUN: begin
        if (fill_we) begin
          cnt_d = cnt_q + 1'b1;
          if (fill_done) begin
            state_d = FILL_IDLE;
          end
        end
      end
      default: state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/dm_wb_cache.sv
`timescale 1ns/1ps
module dm_wb_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int BOFF_W = $clog2(DATA_W / cache_pkg::BYTE_BITS);
  localparam int WO_W   = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - BOFF_W - WO_W - IDX_W;

  logic [TAG_W-1:0]        req_tag;
  logic [IDX_W-1:0]        req_idx;
  logic [WO_W-1:0]         req_woff;
  logic [BOFF_W-1:0]       unused_boff;
  logic                    line_valid;
  logic                    line_dirty;
  logic [TAG_W-1:0]        line_tag;
  logic [WORDS*DATA_W-1:0] line_data;
  logic                    hit;
  logic                    fill_active;
  logic [WO_W-1:0]         fill_woff;
  logic                    fill_we;
  logic                    fill_done;
  logic                    buf_load;
  logic                    buf_busy;
  logic                    wb_req;
  logic [ADDR_W-1:0]       wb_addr;
  logic [DATA_W-1:0]       wb_wdata;
  logic                    store_hit;

  cache_addr_split #(
    .ADDR_W (ADDR_W),
    .BOFF_W (BOFF_W),
    .WO_W   (WO_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .addr (cpu_addr),
    .tag  (req_tag),
    .idx  (req_idx),
    .woff (req_woff),
    .boff (unused_boff)
  );

  cache_store #(
    .LINES  (LINES),
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (req_idx),
    .rd_woff   (req_woff),
    .rd_valid  (line_valid),
    .rd_dirty  (line_dirty),
    .rd_tag    (line_tag),
    .rd_word   (cpu_rdata),
    .rd_line   (line_data),
    .fill_we   (fill_we),
    .fill_woff (fill_woff),
    .fill_data (mem_rdata),
    .fill_done (fill_done),
    .fill_tag  (req_tag),
    .cpu_we    (store_hit),
    .cpu_data  (cpu_wdata)
  );

  assign hit       = line_valid && (line_tag == req_tag);
  assign store_hit = cpu_ready && cpu_write;

  cache_ctrl #(
    .WORDS (WORDS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .hit          (hit),
    .victim_dirty (line_valid && line_dirty),
    .buf_busy     (buf_busy),
    .mem_ready    (mem_ready),
    .cpu_ready    (cpu_ready),
    .fill_active  (fill_active),
    .fill_woff    (fill_woff),
    .fill_we      (fill_we),
    .fill_done    (fill_done),
    .buf_load     (buf_load)
  );

  cache_wbuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W)
  ) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (buf_load),
    .load_tag  (line_tag),
    .load_idx  (req_idx),
    .load_line (line_data),
    .hold      (fill_active),
    .busy      (buf_busy),
    .req       (wb_req),
    .addr      (wb_addr),
    .wdata     (wb_wdata),
    .mem_ready (mem_ready)
  );

  // Port owner: refill reads first, held-line writes otherwise.
  assign mem_req   = fill_active || wb_req;
  assign mem_we    = wb_req;
  assign mem_addr  = fill_active ? {req_tag, req_idx, fill_woff, {BOFF_W{1'b0}}} : wb_addr;
  assign mem_wdata = wb_wdata;

endmodule

// File: rtl/cache_chk.sv
`timescale 1ns/1ps
module cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);

  localparam int CW = $clog2(WORDS);

  // Position inside the current refill run, counted from port traffic.
  logic [CW-1:0] rd_pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos_q <= '0;
    end else if (mem_req && !mem_we && mem_ready) begin
      rd_pos_q <= rd_pos_q + 1'b1;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4
  ready_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_valid && !(mem_req && !mem_we)));

  // R7
  wb_not_mid_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (rd_pos_q == '0));

  // R1
  mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R5
  rdata_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !$isunknown(cpu_rdata));

endmodule

bind dm_wb_cache cache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WORDS  (WORDS)
) u_chk (.*);

// File: tb/tb_dm_wb_cache.sv
`timescale 1ns/1ps
module tb_dm_wb_cache;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NW = 1 << (AW - 2);
  localparam int NV = 14;

  logic          clk;
  logic          rst_n;
  logic          cpu_valid;
  logic          cpu_write;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready;
  logic [DW-1:0] mem_rdata;

  dm_wb_cache dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Main memory model and the processor-visible reference copy.
  logic [DW-1:0] mem_arr [NW];
  logic [DW-1:0] ref_mem [NW];
  logic [1:0]    tick;
  int            rd_count;
  int            wr_count;
  logic [1:0]    rd_pos;
  logic [3:0]    cur_line;
  logic          seq_bad;
  logic          order_bad;
  int            checks;
  int            errors;

  function automatic logic [DW-1:0] seed_word(input int i);
    return {8'h5A, 8'(i), 8'(~i), 8'(i * 3)};
  endfunction

  assign mem_ready = (tick != 2'b11);
  assign mem_rdata = mem_arr[mem_addr[AW-1:2]];

  always @(posedge clk) begin
    tick <= tick + 2'd1;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem_arr[mem_addr[AW-1:2]] <= mem_wdata;
        wr_count <= wr_count + 1;
        if (rd_pos != 2'd0) order_bad <= 1'b1;
      end else begin
        rd_count <= rd_count + 1;
        if (mem_addr[3:2] != rd_pos) seq_bad <= 1'b1;
        if (mem_addr[7:4] != cur_line) seq_bad <= 1'b1;
        rd_pos <= rd_pos + 2'd1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waited, output int nreads, output logic [DW-1:0] data);
    int rd0;
    @(negedge clk);
    rd0       = rd_count;
    cur_line  = a[7:4];
    cpu_valid = 1'b1;
    cpu_write = wr;
    cpu_addr  = a;
    cpu_wdata = d;
    waited    = 0;
    #1;
    while (!cpu_ready && waited < 300) begin
      @(negedge clk);
      #1;
      waited++;
    end
    data = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    nreads = rd_count - rd0;
    if (wr) ref_mem[a[AW-1:2]] = d;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {expected hit, write, address, write data}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h0C, 32'h0},            // cold miss, index 0
    {1'b0, 1'b0, 8'h68, 32'h0},            // cold miss, index 2 tag 1
    {1'b1, 1'b0, 8'h60, 32'h0},            // same line, other word
    {1'b1, 1'b1, 8'h64, 32'hDEAD_0001},    // store hit
    {1'b1, 1'b0, 8'h64, 32'h0},            // read back store
    {1'b0, 1'b0, 8'hAC, 32'h0},            // index 2 tag 2: dirty eviction
    {1'b1, 1'b0, 8'h08, 32'h0},            // index 0 still present
    {1'b0, 1'b1, 8'h10, 32'hBEEF_0002},    // store miss
    {1'b1, 1'b0, 8'h10, 32'h0},            // merged store data
    {1'b0, 1'b0, 8'h64, 32'h0},            // re-read written-back word
    {1'b0, 1'b1, 8'hE0, 32'h1234_5678},    // store miss, tag 3 index 2
    {1'b0, 1'b0, 8'hA0, 32'h0},            // evicts modified tag 3 line
    {1'b0, 1'b0, 8'hE0, 32'h0},            // reload from memory
    {1'b1, 1'b0, 8'hE3, 32'h0}             // byte offset alias
  };

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int w;
    int nr;
    logic [DW-1:0] rd;
    logic [DW-1:0] exp;
    int wr0;

    checks = 0; errors = 0;
    rd_count = 0; wr_count = 0; rd_pos = 2'd0; cur_line = 4'd0;
    seq_bad = 1'b0; order_bad = 1'b0; tick = 2'd0;
    for (int i = 0; i < NW; i++) begin
      mem_arr[i] = seed_word(i);
      ref_mem[i] = seed_word(i);
    end
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    settle(3);
    #1;
    check(cpu_ready == 1'b0, "R2 ready in reset", {31'b0, cpu_ready}, 32'd0);
    check(mem_req == 1'b0, "R2 mem_req in reset", {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic vhit;
      logic vwr;
      logic [AW-1:0] va;
      logic [DW-1:0] vd;
      {vhit, vwr, va, vd} = VEC[v];
      exp = ref_mem[va[AW-1:2]];
      access(vwr, va, vd, w, nr, rd);
      if (vhit) begin
        check(w == 0 && nr == 0, "R3 hit outcome", w, 0);
      end else begin
        check(w > 0 && nr == 4, "R4 miss refill reads", nr, 4);
      end
      if (!vwr) check(rd == exp, "R5 read data", rd, exp);
      if (v == 4) begin
        settle(10);
        check(mem_arr[8'h64 >> 2] == seed_word(8'h64 >> 2), "R6 memory untouched by store hit",
              mem_arr[8'h64 >> 2], seed_word(8'h64 >> 2));
      end
      if (v == 8) check(rd == 32'hBEEF_0002, "R8 store miss merged", rd, 32'hBEEF_0002);
      if (v == 9) check(rd == 32'hDEAD_0001, "R9 victim drained before reread", rd, 32'hDEAD_0001);
    end
    settle(20);
    check(mem_arr[8'h64 >> 2] == 32'hDEAD_0001, "R7 written-back word", mem_arr[8'h64 >> 2],
          32'hDEAD_0001);
    check(mem_arr[8'hE0 >> 2] == 32'h1234_5678, "R7 merged line written back",
          mem_arr[8'hE0 >> 2], 32'h1234_5678);
    check(mem_arr[8'h68 >> 2] == seed_word(8'h68 >> 2), "R7 untouched words of victim",
          mem_arr[8'h68 >> 2], seed_word(8'h68 >> 2));
    check(order_bad == 1'b0, "R7 no write inside refill", {31'b0, order_bad}, 32'd0);
    check(seq_bad == 1'b0, "R4 refill order and address", {31'b0, seq_bad}, 32'd0);

    // R10: clean evictions write nothing.
    access(1'b0, 8'h30, '0, w, nr, rd);
    settle(10);
    wr0 = wr_count;
    access(1'b0, 8'h70, '0, w, nr, rd);
    settle(10);
    check(wr_count == wr0, "R10 clean eviction writes", wr_count, wr0);
    check(rd == ref_mem[8'h70 >> 2], "R5 read after clean eviction", rd, ref_mem[8'h70 >> 2]);

    // R9: modified line evicted then read straight back.
    access(1'b1, 8'h08, 32'h0BAD_0008, w, nr, rd);
    check(w == 0, "R6 store hit immediate", w, 0);
    access(1'b0, 8'h48, '0, w, nr, rd);
    access(1'b0, 8'h08, '0, w, nr, rd);
    check(w > 0 && rd == 32'h0BAD_0008, "R9 reread of evicted modified word", rd, 32'h0BAD_0008);

    // R1: byte offset alias and distinct words in one line.
    access(1'b0, 8'h0B, '0, w, nr, rd);
    check(w == 0 && rd == 32'h0BAD_0008, "R1 byte offset ignored", rd, 32'h0BAD_0008);
    access(1'b0, 8'h05, '0, w, nr, rd);
    check(rd == ref_mem[1], "R1 word select", rd, ref_mem[1]);

    // R2: reset in mid-run drops every line.
    settle(20);
    rst_n = 1'b0;
    settle(2);
    rst_n = 1'b1;
    access(1'b0, 8'h70, '0, w, nr, rd);
    check(w > 0 && nr == 4, "R2 miss after reset", nr, 4);
    check(rd == ref_mem[8'h70 >> 2], "R5 data after reset", rd, ref_mem[8'h70 >> 2]);
    check(seq_bad == 1'b0 && order_bad == 1'b0, "R11 transfer discipline",
          {30'b0, seq_bad, order_bad}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule